// File: doc/BRIEF.md
# I2C Four-Way Channel-Select Register

This block is the target-side register logic of a four-way I2C bus switch. It takes events from a byte-level I2C front end, which has already decoded the bit-level signalling. The events are START, STOP, a received byte and a request for a byte to transmit. Each transfer opens with an address byte. The block compares that byte against its own 7-bit address, which has a fixed upper nibble and three strap inputs, and it acknowledges only when the two match.

On a write, each data byte that follows is acknowledged and its low three bits are stored in the control register. On a read, the block returns a byte with three parts. The stored selection sits in the low bits, bit 3 is zero, and the upper nibble holds the four interrupt lines as they stand at the moment of the request.

The channel-enable vector is driven from a separate active copy of the selection. That copy loads from the control register only when a STOP is seen. A new selection therefore connects a channel only once the bus is idle. A repeated START does not apply it.

Top module: `chsel_top`

## Requirements
- R1: The address byte matches when bits 7:4 equal 1110 and bits 3:1 equal strap_addr. A matching address byte gets ack high in the cycle after its rx_valid. A non-matching one gets no ack, and the data bytes of that transfer get no ack and leave the register unchanged.
- R2: Bit 0 of a matching address byte selects the direction: 1 starts a read phase and 0 starts a write phase.
- R3: In a write phase, every data byte is acknowledged in the cycle after its rx_valid and overwrites the control register, so the last byte before STOP is the one kept.
- R4: When bit 2 of the stored selection is 0, ch_en is all zeros, whatever bits 1:0 hold.
- R5: When bit 2 is 1, ch_en is one-hot, with bit n set, where n is the binary value of bits 1:0. ch_en never has more than one bit set.
- R6: ch_en changes only in the cycle after a bus_stop pulse, when it takes the value decoded from the control register.
- R7: After reset, the control register, the active selection and ch_en are all zero, and a read returns 0 in bits 3:0.
- R8: A read request in a read phase gives tx_valid in the next cycle. tx_data carries irq_in[3:0] in bits 7:4 (bit 4 is channel 0), 0 in bit 3, and the stored selection in bits 2:0. Bits 7:3 of written bytes have no effect.
- R9: A write phase closed by a repeated START leaves ch_en unchanged until a later STOP. That STOP then applies the stored selection.
- R10: A read request outside an addressed read phase gives no tx_valid, and a byte received during a read phase is neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 3 | Address bits 3:1 taken from strap inputs |
| bus_start | input | 1 | One-cycle pulse on a START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on a STOP |
| rx_valid | input | 1 | One-cycle pulse when rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | One-cycle pulse when the front end needs a byte to send |
| irq_in | input | 4 | Active-high interrupt status, one bit per channel |
| ack | output | 1 | One-cycle pulse acknowledging the last received byte |
| tx_valid | output | 1 | One-cycle pulse when tx_data holds the byte to send |
| tx_data | output | 8 | Byte to send on a read |
| ch_en | output | 4 | Channel-enable vector, one-hot or all zeros |

## Verification
The assertions assume the front end sends well-formed single-cycle events. START, STOP, a received byte and a read request never arrive together, and a STOP never lands in the same cycle as a data byte. Under that assumption, ch_en moving without a STOP in the previous cycle is a real fault, not an artefact of the stimulus. The bench drives each event as one isolated pulse at the falling edge and puts an idle cycle between pulses. It never overlaps two events, so every antecedent the checker uses falls inside that contract.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int N_CH    = 4;
  localparam int SEL_W   = $clog2(N_CH) + 1;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam logic [3:0] ADDR_FIXED = 4'b1110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_WRITE, PH_READ, PH_SKIP
  } phase_t;

  // Does an address byte (rw bit excluded) target this block?
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [STRAP_W-1:0] strap);
    return (b[7:4] == ADDR_FIXED) && (b[3:1] == strap);
  endfunction

  // Selection code (enable, index) to channel-enable vector
  function automatic logic [N_CH-1:0] sel_decode(input logic [SEL_W-1:0] sel);
    logic [N_CH-1:0] v;
    v = '0;
    if (sel[SEL_W-1]) v[sel[SEL_W-2:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/chsel_bus_fsm.sv
module chsel_bus_fsm
  import chsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               rx_valid,
  input  logic [BYTE_W-1:0]  rx_data,
  input  logic               rd_req,
  output logic               ack,
  output logic               wr_strobe,
  output logic               rd_strobe
);
  phase_t phase;
  logic   addr_ok;

  assign addr_ok   = (phase == PH_ADDR) && rx_valid && addr_hit(rx_data, strap_addr);
  assign wr_strobe = (phase == PH_WRITE) && rx_valid;
  assign rd_strobe = (phase == PH_READ) && rd_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      ack   <= 1'b0;
    end else begin
      ack <= addr_ok || wr_strobe;
      if (bus_start)
        phase <= PH_ADDR;
      else if (bus_stop)
        phase <= PH_IDLE;
      else if (phase == PH_ADDR && rx_valid)
        phase <= addr_ok ? (rx_data[0] ? PH_READ : PH_WRITE) : PH_SKIP;
    end
  end
endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg
  import chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              bus_stop,
  output logic [SEL_W-1:0]  ctrl_sel,
  output logic [N_CH-1:0]   ch_en
);
  logic [SEL_W-1:0] active_sel;
  logic [N_CH-1:0]  dec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_sel   <= '0;
      active_sel <= '0;
    end else begin
      if (wr_strobe) ctrl_sel <= rx_data[SEL_W-1:0];
      if (bus_stop)  active_sel <= ctrl_sel;
    end
  end

  assign dec = sel_decode(active_sel);

  for (genvar i = 0; i < N_CH; i++) begin : g_en
    assign ch_en[i] = dec[i];
  end
endmodule

// File: rtl/chsel_readback.sv
module chsel_readback
  import chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic [N_CH-1:0]   irq_in,
  input  logic [SEL_W-1:0]  ctrl_sel,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  localparam int PAD_W = BYTE_W - N_CH - SEL_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= rd_strobe;
      if (rd_strobe) tx_data <= {irq_in, {PAD_W{1'b0}}, ctrl_sel};
    end
  end
endmodule

// File: rtl/chsel_top.sv
module chsel_top
  import chsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_addr,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rd_req,
  input  logic [3:0]        irq_in,
  output logic              ack,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic [3:0]        ch_en
);
  logic             wr_strobe;
  logic             rd_strobe;
  logic [SEL_W-1:0] ctrl_sel;

  chsel_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .rd_req(rd_req),
    .ack(ack), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe)
  );

  chsel_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .rx_data(rx_data),
    .bus_stop(bus_stop), .ctrl_sel(ctrl_sel), .ch_en(ch_en)
  );

  chsel_readback u_rb (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .irq_in(irq_in),
    .ctrl_sel(ctrl_sel), .tx_valid(tx_valid), .tx_data(tx_data)
  );
endmodule

// File: rtl/chsel_checker.sv
module chsel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_stop,
  input logic       rx_valid,
  input logic       rd_req,
  input logic       wr_strobe,
  input logic       ack,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic [3:0] ch_en
);
  AST_CH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_en)); // R5
  AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_stop |=> $stable(ch_en)); // R6
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(rx_valid)); // R1
  AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> ack); // R3
  AST_TX_BIT3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_data[3]); // R8
  AST_TX_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(rd_req)); // R10
endmodule

bind chsel_top chsel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .rx_valid(rx_valid),
  .rd_req(rd_req), .wr_strobe(wr_strobe), .ack(ack), .tx_valid(tx_valid),
  .tx_data(tx_data), .ch_en(ch_en)
);

// File: tb/chsel_top_bench.sv
`timescale 1ns/1ps
module chsel_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_addr = 3'b101;
  logic       bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [3:0] irq_in = 4'h0;
  logic       ack, tx_valid;
  logic [7:0] tx_data;
  logic [3:0] ch_en;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [7:0] AW = 8'hEA; // 1110_101_0
  localparam logic [7:0] AR = 8'hEB; // 1110_101_1

  always #4 clk = ~clk;

  chsel_top u_chsel_top (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .bus_start(bus_start),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data), .rd_req(rd_req),
    .irq_in(irq_in), .ack(ack), .tx_valid(tx_valid), .tx_data(tx_data), .ch_en(ch_en)
  );

  function automatic logic [3:0] exp_en(input logic [7:0] b);
    return b[2] ? (4'b0001 << b[1:0]) : 4'b0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_ev();
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic stop_ev();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
    @(negedge clk) begin rx_valid = 1'b0; a = ack; end
  endtask

  task automatic fetch(output logic v, output logic [7:0] d);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) begin rd_req = 1'b0; v = tx_valid; d = tx_data; end
  endtask

  task automatic t_reset();
    logic v; logic [7:0] d; logic a;
    chk("R7 ch_en", ch_en, 4'h0);
    irq_in = 4'h0;
    start_ev(); send(AR, a); fetch(v, d); stop_ev();
    chk("R7 read low bits", {v, d[3:0]}, {1'b1, 4'h0});
  endtask

  task automatic t_mismatch();
    logic a;
    start_ev(); send(8'hE8, a);
    chk("R1 no ack on foreign address", a, 1'b0);
    send(8'h07, a);
    chk("R1 no ack on foreign data", a, 1'b0);
    stop_ev();
    chk("R1 register untouched", ch_en, 4'h0);
  endtask

  task automatic t_write_stop();
    logic a;
    start_ev(); send(AW, a);
    chk("R1 ack on own address", a, 1'b1);
    send(8'h06, a);
    chk("R3 data ack", a, 1'b1);
    chk("R6 no change before stop", ch_en, 4'h0);
    stop_ev();
    chk("R5 channel 2 after stop", ch_en, exp_en(8'h06));
  endtask

  task automatic t_multi();
    logic a;
    start_ev(); send(AW, a); send(8'h04, a); send(8'h07, a); stop_ev();
    chk("R3 last byte kept", ch_en, exp_en(8'h07));
  endtask

  task automatic t_disable();
    logic a;
    start_ev(); send(AW, a); send(8'h03, a); stop_ev();
    chk("R4 enable clear", ch_en, 4'h0);
  endtask

  task automatic t_read();
    logic a, v; logic [7:0] d;
    start_ev(); send(AW, a); send(8'hFD, a); stop_ev();
    chk("R5 channel 1", ch_en, 4'b0010);
    irq_in = 4'b0110;
    start_ev(); send(AR, a);
    chk("R2 read address acked", a, 1'b1);
    fetch(v, d);
    chk("R8 read byte", {v, d}, {1'b1, 8'h65});
    send(8'h04, a);
    chk("R10 byte in read phase not acked", a, 1'b0);
    irq_in = 4'b1001;
    fetch(v, d);
    chk("R8 live irq, R10 byte not stored", {v, d}, {1'b1, 8'h95});
    stop_ev();
    chk("R10 ch_en kept", ch_en, 4'b0010);
    start_ev(); send(8'hE9, a); fetch(v, d); stop_ev();
    chk("R10 no tx on foreign read", v, 1'b0);
    start_ev(); send(AW, a); fetch(v, d); stop_ev();
    chk("R10 no tx in write phase", v, 1'b0);
    irq_in = 4'h0;
  endtask

  task automatic t_rep_start();
    logic a, v; logic [7:0] d;
    start_ev(); send(AW, a); send(8'h04, a);
    start_ev(); send(AR, a);
    chk("R9 held across repeated start", ch_en, 4'b0010);
    fetch(v, d);
    chk("R9 pending readable", d[2:0], 3'b100);
    stop_ev();
    chk("R9 applied at later stop", ch_en, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mismatch();
    t_write_stop();
    t_multi();
    t_disable();
    t_read();
    t_rep_start();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule